// File: doc/BRIEF.md
# Core Regulator Soft-Start Sequencer

This block orders the power-up of a core-voltage regulator. It first waits for the supply monitor to report a healthy bias supply and then lets a fixed number of microsecond ticks go by. It then waits for the enable input. Once enabled, it raises a digital reference code from zero to a boot level at a slow rate. It then holds the reference and waits until the output comparator has reported "within 10% of boot" for a run of unbroken switching cycles. At that point it drives an active-low clock-enable output low and slews the reference at twice the ramp rate toward the level requested on a 7-bit voltage-identification bus.

Power-good is asserted once a fixed number of microsecond ticks has passed since the ramp began and the clock-enable output is already low. After power-good, the reference keeps following the identification bus in either direction. Losing the enable, or losing the supply-ok flag, returns the block to its quiet state at once.

The reference is held in 0.5 mV units. In these units the boot level of 1.1 V is 2200, the ramp is 5 units per tick and the slew is 10 units per tick.

Top module: `soft_start_seq`

## Requirements
- R1: After reset `ref_code` is 0, `clk_en_n` is 1 and `pgood` is 0.
- R2: No ramp starts until `por_ok` has been high for POR_DLY (120) `us_tick` pulses and `vr_enable` is high. When `vr_enable` is already high, the 120th tick only arms the block. The next tick is the first ramp step. Enable arriving later starts the ramp with no further delay.
- R3: While ramping, each `us_tick` raises `ref_code` by 5 (2.5 mV). It stops exactly at 2200 (1.1 V) and never passes it.
- R4: After the ramp reaches 2200, `clk_en_n` goes low on the clock edge of the 13th consecutive `sw_cycle` pulse seen with `vout_in_window` high. `ref_code` stays at 2200 until then.
- R5: Any cycle with `vout_in_window` low during the settle count restarts the count from zero. A pulse seen while the flag is low does not count.
- R6: The target for `vid` (bit 0 LSB, bit 6 MSB) is 3000 − 25·vid in 0.5 mV units. Code 0 gives 1.500 V and code 96 gives the 0.300 V floor. Codes 97 to 127 clamp to 600.
- R7: With `clk_en_n` low, each `us_tick` moves `ref_code` 10 units (5 mV) toward the target, up or down. It lands exactly on the target and then holds.
- R8: `pgood` rises after the 7000th `us_tick` counted since the ramp began, but only once `clk_en_n` is low. If settling finishes later, `pgood` rises right after `clk_en_n` falls.
- R9: `vr_enable` low or `por_ok` low clears `ref_code` to 0, returns `clk_en_n` to 1 and drops `pgood` on the next edge. Losing `por_ok` also re-arms the 120-tick delay; losing only the enable does not.
- R10: A `vid` change after `pgood` retargets the slew in either direction and leaves `pgood` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| por_ok | input | 1 | Bias supply above its power-on threshold |
| vr_enable | input | 1 | Regulator enable |
| us_tick | input | 1 | One-cycle pulse each microsecond |
| sw_cycle | input | 1 | One-cycle pulse per switching cycle |
| vout_in_window | input | 1 | Output within 10% of boot level |
| vid | input | 7 | Voltage-identification code |
| ref_code | output | 12 | Reference code in 0.5 mV units |
| clk_en_n | output | 1 | Active-low clock enable |
| pgood | output | 1 | Power-good |

## Verification
The bench looks for off-by-one errors in three counters. In the supply delay, a one-tick slip makes the first ramp step arrive one tick early or late. In the settle count, a slip drops `clk_en_n` on the 12th or 14th pulse. In the power-good timer, a slip raises `pgood` one tick away from the 7000th. It breaks the window flag after twelve good pulses, so a counter that only pauses would release the clock too early. It walks every one of the 128 identification codes, so an error in the step size or in the clamp shows up as a wrong settled reference or as an overshoot past the target. It also lets power-good time out before settling, which catches a design that raises `pgood` while the clock is still disabled.

// File: rtl/ss_seq_pkg.sv
package ss_seq_pkg;
  typedef enum logic [2:0] {
    SQ_PORWAIT = 3'd0,
    SQ_IDLE    = 3'd1,
    SQ_RAMP    = 3'd2,
    SQ_SETTLE  = 3'd3,
    SQ_TRACK   = 3'd4
  } sq_state_t;
endpackage

// File: rtl/ss_vid_map.sv
module ss_vid_map #(
  parameter int VID_W      = 7,
  parameter int REF_W      = 12,
  parameter int TOP_CODE   = 3000,
  parameter int FLOOR_CODE = 600,
  parameter int VID_STEP   = 25
) (
  input  logic [VID_W-1:0] vid,
  output logic [REF_W-1:0] target
);
  localparam int FLOOR_IDX = (TOP_CODE - FLOOR_CODE) / VID_STEP;

  always_comb begin
    if (int'(vid) >= FLOOR_IDX) target = REF_W'(FLOOR_CODE);
    else                        target = REF_W'(TOP_CODE - int'(vid) * VID_STEP);
  end

  always_comb begin
    AST_VID_TARGET_RANGE: assert (int'(target) >= FLOOR_CODE && int'(target) <= TOP_CODE); // R6
  end
endmodule

// File: rtl/ss_ref_step.sv
module ss_ref_step #(
  parameter int REF_W = 12,
  parameter int RATE  = 5
) (
  input  logic [REF_W-1:0] cur,
  input  logic [REF_W-1:0] goal,
  output logic [REF_W-1:0] nxt
);
  logic [REF_W:0]   up_sum;
  logic [REF_W-1:0] gap;

  always_comb begin
    up_sum = {1'b0, cur} + (REF_W+1)'(RATE);
    gap    = '0;
    nxt    = cur;
    if (cur < goal) begin
      if (up_sum >= {1'b0, goal}) nxt = goal;
      else                        nxt = up_sum[REF_W-1:0];
    end else if (cur > goal) begin
      gap = cur - goal;
      if (gap <= REF_W'(RATE)) nxt = goal;
      else                     nxt = cur - REF_W'(RATE);
    end
  end
endmodule

// File: rtl/ss_settle_gate.sv
module ss_settle_gate #(
  parameter int SETTLE_CYC = 13
) (
  input  logic clk,
  input  logic rst_n,
  input  logic arm,
  input  logic in_win,
  input  logic cyc,
  output logic done
);
  localparam int CW = $clog2(SETTLE_CYC + 1);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    done  = 1'b0;
    if (!arm || !in_win) begin
      cnt_d = '0;
    end else if (cyc) begin
      if (cnt_q == CW'(SETTLE_CYC - 1)) begin
        done  = 1'b1;
        cnt_d = '0;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  AST_SETTLE_BREAK: assert property (@(posedge clk) disable iff (!rst_n)
    (arm && !in_win) |=> (cnt_q == '0)); // R5
  AST_SETTLE_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    int'(cnt_q) < SETTLE_CYC); // R4
endmodule

// File: rtl/soft_start_seq.sv
module soft_start_seq
  import ss_seq_pkg::*;
#(
  parameter int VID_W      = 7,
  parameter int REF_W      = 12,
  parameter int TOP_CODE   = 3000,
  parameter int FLOOR_CODE = 600,
  parameter int VID_STEP   = 25,
  parameter int BOOT_CODE  = 2200,
  parameter int RAMP_STEP  = 5,
  parameter int SLEW_STEP  = 10,
  parameter int SETTLE_CYC = 13,
  parameter int POR_DLY    = 120,
  parameter int PG_DLY     = 7000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             por_ok,
  input  logic             vr_enable,
  input  logic             us_tick,
  input  logic             sw_cycle,
  input  logic             vout_in_window,
  input  logic [VID_W-1:0] vid,
  output logic [REF_W-1:0] ref_code,
  output logic             clk_en_n,
  output logic             pgood
);
  localparam int PW = $clog2(POR_DLY + 1);
  localparam int GW = $clog2(PG_DLY + 1);
  localparam logic [REF_W-1:0] BOOT_REF = REF_W'(BOOT_CODE);

  sq_state_t        st_q, st_d;
  logic [REF_W-1:0] ref_q, ref_d;
  logic [PW-1:0]    por_cnt_q, por_cnt_d;
  logic [GW-1:0]    pg_cnt_q, pg_cnt_d;
  logic             pgood_q, pgood_d;

  logic [REF_W-1:0] vid_target, ramp_nxt, slew_nxt;
  logic             settle_done, in_seq;

  ss_vid_map #(
    .VID_W(VID_W), .REF_W(REF_W), .TOP_CODE(TOP_CODE),
    .FLOOR_CODE(FLOOR_CODE), .VID_STEP(VID_STEP)
  ) u_vid_map (
    .vid(vid), .target(vid_target)
  );

  ss_ref_step #(.REF_W(REF_W), .RATE(RAMP_STEP)) u_ramp_step (
    .cur(ref_q), .goal(BOOT_REF), .nxt(ramp_nxt)
  );

  ss_ref_step #(.REF_W(REF_W), .RATE(SLEW_STEP)) u_slew_step (
    .cur(ref_q), .goal(vid_target), .nxt(slew_nxt)
  );

  ss_settle_gate #(.SETTLE_CYC(SETTLE_CYC)) u_settle (
    .clk(clk), .rst_n(rst_n), .arm(st_q == SQ_SETTLE),
    .in_win(vout_in_window), .cyc(sw_cycle), .done(settle_done)
  );

  assign in_seq = (st_q == SQ_RAMP) || (st_q == SQ_SETTLE) || (st_q == SQ_TRACK);

  always_comb begin
    st_d      = st_q;
    ref_d     = ref_q;
    por_cnt_d = por_cnt_q;
    pg_cnt_d  = pg_cnt_q;
    pgood_d   = pgood_q;

    if (in_seq && us_tick && pg_cnt_q != GW'(PG_DLY))
      pg_cnt_d = pg_cnt_q + 1'b1;

    case (st_q)
      SQ_PORWAIT: begin
        ref_d    = '0;
        pgood_d  = 1'b0;
        pg_cnt_d = '0;
        if (us_tick) begin
          if (por_cnt_q == PW'(POR_DLY - 1)) begin
            st_d      = SQ_IDLE;
            por_cnt_d = '0;
          end else begin
            por_cnt_d = por_cnt_q + 1'b1;
          end
        end
      end
      SQ_IDLE: begin
        ref_d    = '0;
        pgood_d  = 1'b0;
        pg_cnt_d = '0;
        if (vr_enable) st_d = SQ_RAMP;
      end
      SQ_RAMP: begin
        if (ref_q == BOOT_REF) st_d  = SQ_SETTLE;
        else if (us_tick)      ref_d = ramp_nxt;
      end
      SQ_SETTLE: begin
        if (settle_done) st_d = SQ_TRACK;
      end
      SQ_TRACK: begin
        if (us_tick) ref_d = slew_nxt;
        if (pg_cnt_q == GW'(PG_DLY)) pgood_d = 1'b1;
      end
      default: st_d = SQ_PORWAIT;
    endcase

    if (!por_ok) begin
      st_d      = SQ_PORWAIT;
      por_cnt_d = '0;
      ref_d     = '0;
      pg_cnt_d  = '0;
      pgood_d   = 1'b0;
    end else if (!vr_enable && in_seq) begin
      st_d     = SQ_IDLE;
      ref_d    = '0;
      pg_cnt_d = '0;
      pgood_d  = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= SQ_PORWAIT;
      ref_q     <= '0;
      por_cnt_q <= '0;
      pg_cnt_q  <= '0;
      pgood_q   <= 1'b0;
    end else begin
      st_q      <= st_d;
      ref_q     <= ref_d;
      por_cnt_q <= por_cnt_d;
      pg_cnt_q  <= pg_cnt_d;
      pgood_q   <= pgood_d;
    end
  end

  assign ref_code = ref_q;
  assign clk_en_n = (st_q != SQ_TRACK);
  assign pgood    = pgood_q;

  AST_RAMP_NO_OVERSHOOT: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == SQ_RAMP) |=> (ref_q <= BOOT_REF)); // R3
  AST_CLKEN_AT_BOOT: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(clk_en_n) |-> (ref_q == BOOT_REF)); // R4
  AST_PG_NEEDS_CLKEN: assert property (@(posedge clk) disable iff (!rst_n)
    pgood |-> !clk_en_n); // R8
  AST_QUIET_ON_POR_LOSS: assert property (@(posedge clk) disable iff (!rst_n)
    !por_ok |=> (ref_q == '0 && clk_en_n && !pgood)); // R9
  AST_SLEW_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == SQ_TRACK && $past(st_q) == SQ_TRACK) |->
      (({1'b0, ref_q} <= {1'b0, $past(ref_q)} + (REF_W+1)'(SLEW_STEP)) &&
       ({1'b0, $past(ref_q)} <= {1'b0, ref_q} + (REF_W+1)'(SLEW_STEP)))); // R7
endmodule

// File: tb/soft_start_seq_bench.sv
module soft_start_seq_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       por_ok = 1'b0;
  logic       vr_enable = 1'b0;
  logic       us_tick = 1'b0;
  logic       sw_cycle = 1'b0;
  logic       vout_in_window = 1'b0;
  logic [6:0] vid = 7'd0;
  logic [11:0] ref_code;
  logic       clk_en_n;
  logic       pgood;

  int checks = 0;
  int failures = 0;
  int seq_ticks = 0;
  bit running = 0;
  bit finished = 0;
  int exp_ref;

  always #4 clk = ~clk;

  soft_start_seq u_soft_start_seq (
    .clk(clk), .rst_n(rst_n), .por_ok(por_ok), .vr_enable(vr_enable),
    .us_tick(us_tick), .sw_cycle(sw_cycle), .vout_in_window(vout_in_window),
    .vid(vid), .ref_code(ref_code), .clk_en_n(clk_en_n), .pgood(pgood)
  );

  function automatic int vid_goal(int v);
    return (v >= 96) ? 600 : 3000 - 25 * v;
  endfunction

  function automatic int step_to(int cur, int goal, int rate);
    if (cur < goal) return (cur + rate >= goal) ? goal : cur + rate;
    if (cur > goal) return (cur - goal <= rate) ? goal : cur - rate;
    return cur;
  endfunction

  task automatic chk(bit ok, string req, int act, int expv);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic tick();
    @(negedge clk) us_tick = 1'b1;
    @(negedge clk) us_tick = 1'b0;
    @(negedge clk);
    if (running) seq_ticks++;
  endtask

  task automatic pulse();
    @(negedge clk) sw_cycle = 1'b1;
    @(negedge clk) sw_cycle = 1'b0;
    @(negedge clk);
  endtask

  task automatic ramp_all();
    exp_ref = 0;
    for (int k = 1; k <= 441; k++) begin
      tick();
      exp_ref = step_to(exp_ref, 2200, 5);
      chk(ref_code == 12'(exp_ref), "R3 ramp step", int'(ref_code), exp_ref);
    end
  endtask

  initial begin
    int cyc = 0;
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 190000 && !finished) begin
        finished = 1;
        failures++;
        $display("FAIL watchdog actual=%0d expected=%0d", cyc, 190000);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
      end
    end
  end

  initial begin
    idle(3);
    // R1 reset state
    chk(ref_code == 0, "R1 ref", int'(ref_code), 0);
    chk(clk_en_n == 1, "R1 clk_en_n", int'(clk_en_n), 1);
    chk(pgood == 0, "R1 pgood", int'(pgood), 0);
    rst_n = 1'b1;
    idle(2);

    // R2 no start without enable
    por_ok = 1'b1;
    for (int i = 0; i < 150; i++) tick();
    chk(ref_code == 0, "R2 no enable", int'(ref_code), 0);
    vr_enable = 1'b1;
    idle(2);
    running = 1;
    ramp_all();
    chk(clk_en_n == 1, "R4 held before settle", int'(clk_en_n), 1);

    // R4 / R5 settle count with a break
    vid = 7'd0;
    vout_in_window = 1'b1;
    for (int i = 0; i < 12; i++) pulse();
    chk(clk_en_n == 1, "R4 twelve pulses", int'(clk_en_n), 1);
    vout_in_window = 1'b0;
    pulse();
    vout_in_window = 1'b1;
    for (int i = 0; i < 12; i++) pulse();
    chk(clk_en_n == 1, "R5 restart after break", int'(clk_en_n), 1);
    chk(ref_code == 2200, "R4 ref held", int'(ref_code), 2200);
    pulse();
    chk(clk_en_n == 0, "R4 thirteenth pulse", int'(clk_en_n), 0);

    // R7 slew up, R8 power-good timing
    exp_ref = 2200;
    while (seq_ticks < 7000) begin
      tick();
      exp_ref = step_to(exp_ref, vid_goal(0), 10);
      chk(ref_code == 12'(exp_ref), "R7 slew", int'(ref_code), exp_ref);
      chk(pgood == (seq_ticks >= 7000), "R8 pgood time", int'(pgood), int'(seq_ticks >= 7000));
    end

    // R6 / R10 full VID sweep, downward then upward
    for (int v = 0; v < 128; v++) begin
      vid = 7'(v);
      while (exp_ref != vid_goal(v)) begin
        tick();
        exp_ref = step_to(exp_ref, vid_goal(v), 10);
        chk(ref_code == 12'(exp_ref), "R10 retarget step", int'(ref_code), exp_ref);
      end
      tick();
      chk(ref_code == 12'(vid_goal(v)), "R6 vid target", int'(ref_code), vid_goal(v));
      chk(pgood == 1, "R10 pgood kept", int'(pgood), 1);
    end
    vid = 7'd0;
    while (exp_ref != 3000) begin
      tick();
      exp_ref = step_to(exp_ref, 3000, 10);
      chk(ref_code == 12'(exp_ref), "R7 slew up", int'(ref_code), exp_ref);
    end

    // R9 enable drop
    @(negedge clk) vr_enable = 1'b0;
    @(negedge clk);
    chk(ref_code == 0, "R9 enable drop ref", int'(ref_code), 0);
    chk(clk_en_n == 1, "R9 enable drop clk_en_n", int'(clk_en_n), 1);
    chk(pgood == 0, "R9 enable drop pgood", int'(pgood), 0);
    vr_enable = 1'b1;
    idle(2);
    tick();
    chk(ref_code == 5, "R9 restart without delay", int'(ref_code), 5);

    // R9 supply loss, R2 strapped enable
    running = 0;
    seq_ticks = 0;
    @(negedge clk) por_ok = 1'b0;
    @(negedge clk);
    chk(ref_code == 0, "R9 por loss ref", int'(ref_code), 0);
    chk(clk_en_n == 1, "R9 por loss clk_en_n", int'(clk_en_n), 1);
    vout_in_window = 1'b0;
    por_ok = 1'b1;
    for (int i = 0; i < 120; i++) tick();
    chk(ref_code == 0, "R2 strap tick 120", int'(ref_code), 0);
    running = 1;
    ramp_all();

    // R8 power-good waits for clock enable
    while (seq_ticks < 7010) tick();
    chk(pgood == 0, "R8 pgood waits", int'(pgood), 0);
    chk(clk_en_n == 1, "R4 no window no enable", int'(clk_en_n), 1);
    vout_in_window = 1'b1;
    for (int i = 0; i < 13; i++) pulse();
    chk(clk_en_n == 0, "R4 late settle", int'(clk_en_n), 0);
    chk(pgood == 1, "R8 pgood after late settle", int'(pgood), 1);

    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule